// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small direct-mapped cache that fetch consults with the current fetch address. In the same cycle it reports whether that address is a known branch. It also gives the address to fetch next: the stored target when the matching entry says taken, and the sequential address (fetch address plus 4) in every other case. A correctly predicted taken branch that hits therefore redirects fetch with no bubble.

When a branch resolves later in the pipeline, the resolve port carries the branch address, its real direction, its real target and the next address that fetch actually used after it. The block works out the true next address and compares it with the one fetch used. On a difference it raises a one-cycle flush with the corrected address on the cycle after the resolve. In the same step it keeps its entries current. A taken branch writes or overwrites its entry. A not-taken branch that has an entry only loses its taken bit. A not-taken branch without an entry leaves the table alone.

Top module: `branch_target_buffer`

## Requirements
- R1: While the synchronous active-low reset is applied, every entry is marked invalid. After reset no fetch address hits, and the next fetch address is the fetch address plus 4.
- R2: An entry is chosen by fetch address bits [IDX_W+1:2] and tagged with bits [PC_W-1:IDX_W+2]. A hit requires a valid entry whose tag equals the fetch tag, so a second address that maps to the same index with a different tag misses.
- R3: In the same cycle, a hit on an entry whose taken bit is set drives the stored target as the next fetch address.
- R4: On a miss, or on a hit whose taken bit is clear, the next fetch address is the fetch address plus 4, modulo 2^PC_W.
- R5: A resolved taken branch writes its entry (valid, tag, target, taken bit set). Lookups see the new entry from the cycle after the resolve.
- R6: A resolved not-taken branch whose entry hits clears only that entry's taken bit. The entry still hits, and it predicts fetch address plus 4.
- R7: A resolved not-taken branch with no matching entry changes nothing. An entry with a different tag at the same index keeps hitting with its old target.
- R8: When the true next address (the target if taken, otherwise the branch address plus 4) differs from the address fetch used, flush_redirect is high for the single cycle after the resolve, and redirect_pc carries the true next address.
- R9: When the true next address equals the address fetch used, flush_redirect stays low in the following cycle, so a correctly predicted branch costs no cycle.
- R10: When a resolve writes an entry in the same cycle as a lookup of that entry's index, the lookup returns the contents from before the write.
- R11: A resolved taken branch whose index holds another tag replaces that entry. The old address then misses, and the new address hits with the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| lookup_hit | output | 1 | Fetch address matches a valid entry |
| next_fetch_pc | output | PC_W | Predicted next fetch address |
| resolve_valid | input | 1 | A branch outcome is presented this cycle |
| resolve_pc | input | PC_W | Address of the resolved branch |
| resolve_taken | input | 1 | The branch was actually taken |
| resolve_target | input | PC_W | Actual target of the branch |
| resolve_pred_pc | input | PC_W | Next address that fetch used after this branch |
| flush_redirect | output | 1 | One-cycle kill of wrong-path work and redirect of fetch |
| redirect_pc | output | PC_W | Corrected fetch address, valid with flush_redirect |

## Verification
The hardest case to reach is a resolve that changes an entry in the same cycle that fetch looks up the same index. This covers both the read-before-write rule and a taken bit flipping under a live lookup. The stimulus presents the resolve and the same fetch address together in one cycle, then repeats the fetch in the next cycle so that both the old and the new contents are compared. Aliasing at one index is reached on purpose with addresses that differ only above the index bits. A loop branch is then driven through several iterations and an exit, using the model's own predictions as the addresses fetch used, so the flush count follows the expected penalty pattern.

// File: rtl/btb_pkg.sv
// Package: shared types for the branch target buffer.
// Assumes: one resolve per cycle at most; actions are mutually exclusive.
package btb_pkg;

    // Table update chosen for a resolved branch.
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_INSERT  = 2'd1,
        ACT_CLR_TKN = 2'd2
    } btb_act_e;

endpackage

// File: rtl/btb_store.sv
// Module: btb_store
// Direct-mapped entry table with a combinational lookup port, a combinational
// probe port for the resolve side, and one registered update per cycle.
// Assumes: reads return contents from before any write at the same clock edge.
module btb_store #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int TAG_W = PC_W - IDX_W - 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [TAG_W-1:0]     rd_tag,
    output logic                 rd_hit,
    output logic                 rd_taken,
    output logic [PC_W-1:0]      rd_target,
    input  logic [IDX_W-1:0]     pb_idx,
    input  logic [TAG_W-1:0]     pb_tag,
    output logic                 pb_hit,
    input  btb_pkg::btb_act_e    act,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic [PC_W-1:0]      wr_target
);
    import btb_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]  valid_q;
    logic [DEPTH-1:0]  taken_q;
    logic [TAG_W-1:0]  tag_q [DEPTH];
    logic [PC_W-1:0]   tgt_q [DEPTH];

    // Valid and taken bits: cleared by reset, set on insert, taken cleared on demand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            taken_q <= '0;
        end else begin
            if (act == ACT_INSERT) begin
                valid_q[wr_idx] <= 1'b1;
                taken_q[wr_idx] <= 1'b1;
            end else if (act == ACT_CLR_TKN) begin
                taken_q[wr_idx] <= 1'b0;
            end
        end
    end

    // Tag and target payload: written on insert only, no reset needed.
    always_ff @(posedge clk) begin
        if (act == ACT_INSERT) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

    // Fetch-side lookup: hit needs valid and matching tag.
    always_comb begin
        rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_taken  = taken_q[rd_idx];
        rd_target = tgt_q[rd_idx];
    end

    // Resolve-side probe: tells the controller whether the branch has an entry.
    always_comb begin
        pb_hit = valid_q[pb_idx] && (tag_q[pb_idx] == pb_tag);
    end

    assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !rd_hit && !pb_hit);

    assert_insert_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(act == ACT_INSERT) && rd_idx == $past(wr_idx)
         && rd_tag == $past(wr_tag)) |-> (rd_hit && rd_taken && rd_target == $past(wr_target)));

    assert_clear_keeps_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(act == ACT_CLR_TKN) && $past(pb_hit) && rd_idx == $past(wr_idx)
         && rd_tag == $past(wr_tag)) |-> (rd_hit && !rd_taken));

endmodule

// File: rtl/btb_resolve_ctl.sv
// Module: btb_resolve_ctl
// Turns a resolved branch into a table action and a registered one-cycle
// flush/redirect when the address fetch used differs from the true next one.
// Assumes: probe_hit reflects the table for resolve_pc in the same cycle.
module btb_resolve_ctl #(
    parameter int PC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               resolve_valid,
    input  logic [PC_W-1:0]    resolve_pc,
    input  logic               resolve_taken,
    input  logic [PC_W-1:0]    resolve_target,
    input  logic [PC_W-1:0]    resolve_pred_pc,
    input  logic               probe_hit,
    output btb_pkg::btb_act_e  act,
    output logic               redirect_q,
    output logic [PC_W-1:0]    redirect_pc_q
);
    import btb_pkg::*;

    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic [PC_W-1:0] true_next;
    logic            mispredict;

    // True successor of the branch and comparison with what fetch used.
    always_comb begin
        true_next  = resolve_taken ? resolve_target : (resolve_pc + STEP);
        mispredict = resolve_valid && (true_next != resolve_pred_pc);
    end

    // Table action: taken writes, not-taken with entry clears taken bit.
    always_comb begin
        act = ACT_NONE;
        if (resolve_valid) begin
            if (resolve_taken)  act = ACT_INSERT;
            else if (probe_hit) act = ACT_CLR_TKN;
        end
    end

    // Registered flush pulse and corrected address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_q    <= 1'b0;
            redirect_pc_q <= '0;
        end else begin
            redirect_q    <= mispredict;
            if (mispredict) redirect_pc_q <= true_next;
        end
    end

    assert_flush_follows_resolve_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_q |-> ($past(rst_n) && $past(resolve_valid)
                        && redirect_pc_q != $past(resolve_pred_pc)));

    assert_no_flush_when_right_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(resolve_valid) && $past(true_next == resolve_pred_pc))
        |-> !redirect_q);

    assert_no_flush_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(resolve_valid)) |-> !redirect_q);

endmodule

// File: rtl/branch_target_buffer.sv
// Module: branch_target_buffer (top)
// Fetch-stage next-address predictor with a resolve port that trains the
// table and raises a one-cycle flush with the corrected address.
// Assumes: fetch_pc is word aligned; resolve_pred_pc is the address fetch
// actually took after the branch.
module branch_target_buffer #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            lookup_hit,
    output logic [PC_W-1:0] next_fetch_pc,
    input  logic            resolve_valid,
    input  logic [PC_W-1:0] resolve_pc,
    input  logic            resolve_taken,
    input  logic [PC_W-1:0] resolve_target,
    input  logic [PC_W-1:0] resolve_pred_pc,
    output logic            flush_redirect,
    output logic [PC_W-1:0] redirect_pc
);
    import btb_pkg::*;

    localparam int TAG_W = PC_W - IDX_W - 2;
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic [IDX_W-1:0] f_idx, r_idx;
    logic [TAG_W-1:0] f_tag, r_tag;
    logic             rd_hit, rd_taken, pb_hit;
    logic [PC_W-1:0]  rd_target;
    btb_act_e         act;

    // Split fetch and resolve addresses into index and tag.
    always_comb begin
        f_idx = fetch_pc[IDX_W+1:2];
        f_tag = fetch_pc[PC_W-1:IDX_W+2];
        r_idx = resolve_pc[IDX_W+1:2];
        r_tag = resolve_pc[PC_W-1:IDX_W+2];
    end

    btb_store #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (f_idx),
        .rd_tag    (f_tag),
        .rd_hit    (rd_hit),
        .rd_taken  (rd_taken),
        .rd_target (rd_target),
        .pb_idx    (r_idx),
        .pb_tag    (r_tag),
        .pb_hit    (pb_hit),
        .act       (act),
        .wr_idx    (r_idx),
        .wr_tag    (r_tag),
        .wr_target (resolve_target)
    );

    btb_resolve_ctl #(.PC_W(PC_W)) u_ctl (
        .clk             (clk),
        .rst_n           (rst_n),
        .resolve_valid   (resolve_valid),
        .resolve_pc      (resolve_pc),
        .resolve_taken   (resolve_taken),
        .resolve_target  (resolve_target),
        .resolve_pred_pc (resolve_pred_pc),
        .probe_hit       (pb_hit),
        .act             (act),
        .redirect_q      (flush_redirect),
        .redirect_pc_q   (redirect_pc)
    );

    // Next fetch address: stored target on a taken hit, else sequential.
    always_comb begin
        lookup_hit    = rd_hit;
        next_fetch_pc = (rd_hit && rd_taken) ? rd_target : (fetch_pc + STEP);
    end

    assert_new_entry_redirects_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(resolve_valid && resolve_taken) && fetch_pc == $past(resolve_pc))
        |-> (lookup_hit && next_fetch_pc == $past(resolve_target)));

endmodule

// File: tb/tb_branch_target_buffer.sv
module tb_branch_target_buffer;
    localparam int PC_W  = 32;
    localparam int IDX_W = 4;
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W - 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            lookup_hit;
    logic [PC_W-1:0] next_fetch_pc;
    logic            resolve_valid = 1'b0;
    logic [PC_W-1:0] resolve_pc = '0;
    logic            resolve_taken = 1'b0;
    logic [PC_W-1:0] resolve_target = '0;
    logic [PC_W-1:0] resolve_pred_pc = '0;
    logic            flush_redirect;
    logic [PC_W-1:0] redirect_pc;

    always #5 clk = ~clk;

    branch_target_buffer #(.PC_W(PC_W), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .lookup_hit(lookup_hit),
        .next_fetch_pc(next_fetch_pc), .resolve_valid(resolve_valid),
        .resolve_pc(resolve_pc), .resolve_taken(resolve_taken),
        .resolve_target(resolve_target), .resolve_pred_pc(resolve_pred_pc),
        .flush_redirect(flush_redirect), .redirect_pc(redirect_pc)
    );

    typedef struct {
        logic            hit;
        logic [PC_W-1:0] nxt;
        string           req_l;
        logic            redir;
        logic [PC_W-1:0] rpc;
        string           req_r;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   n_flush_seen = 0;
    int   n_flush_exp = 0;

    // Reference table built from the requirements.
    logic             m_val [DEPTH];
    logic             m_tkn [DEPTH];
    logic [TAG_W-1:0] m_tag [DEPTH];
    logic [PC_W-1:0]  m_tgt [DEPTH];
    logic             pend_redir = 1'b0;
    logic [PC_W-1:0]  pend_rpc = '0;
    string            pend_req = "R9";

    function automatic int idx_of(logic [PC_W-1:0] pc);
        return int'(pc[IDX_W+1:2]);
    endfunction

    function automatic logic m_hit(logic [PC_W-1:0] pc);
        return m_val[idx_of(pc)] && m_tag[idx_of(pc)] == pc[PC_W-1:IDX_W+2];
    endfunction

    function automatic logic [PC_W-1:0] m_next(logic [PC_W-1:0] pc);
        if (m_hit(pc) && m_tkn[idx_of(pc)]) return m_tgt[idx_of(pc)];
        return pc + PC_W'(4);
    endfunction

    task automatic check(string req, logic [PC_W-1:0] act, logic [PC_W-1:0] expv, string what);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Driver: one cycle of stimulus; pushes the expected observation for this cycle.
    task automatic step(logic [PC_W-1:0] fpc, logic rv, logic [PC_W-1:0] rpc, logic rt,
                        logic [PC_W-1:0] rtg, logic [PC_W-1:0] rpred, string req_l, string req_r);
        exp_t e;
        logic [PC_W-1:0] tn;
        @(posedge clk);
        #2;
        fetch_pc = fpc; resolve_valid = rv; resolve_pc = rpc;
        resolve_taken = rt; resolve_target = rtg; resolve_pred_pc = rpred;
        e.hit = m_hit(fpc); e.nxt = m_next(fpc); e.req_l = req_l;
        e.redir = pend_redir; e.rpc = pend_rpc; e.req_r = pend_req;
        exp_q.push_back(e);
        pend_redir = 1'b0; pend_req = req_r;
        if (rv) begin
            tn = rt ? rtg : rpc + PC_W'(4);
            if (tn != rpred) begin
                pend_redir = 1'b1; pend_rpc = tn; n_flush_exp++;
            end
            if (rt) begin
                m_val[idx_of(rpc)] = 1'b1; m_tkn[idx_of(rpc)] = 1'b1;
                m_tag[idx_of(rpc)] = rpc[PC_W-1:IDX_W+2]; m_tgt[idx_of(rpc)] = rtg;
            end else if (m_hit(rpc)) begin
                m_tkn[idx_of(rpc)] = 1'b0;
            end
        end
    endtask

    task automatic fetch_only(logic [PC_W-1:0] fpc, string req_l);
        step(fpc, 1'b0, '0, 1'b0, '0, '0, req_l, "R9");
    endtask

    // Monitor: samples late in each cycle and compares with the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #8;
            if (flush_redirect === 1'b1) n_flush_seen++;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req_l, PC_W'(lookup_hit), PC_W'(e.hit), "lookup_hit");
                check(e.req_l, next_fetch_pc, e.nxt, "next_fetch_pc");
                check(e.req_r, PC_W'(flush_redirect), PC_W'(e.redir), "flush_redirect");
                if (e.redir) check(e.req_r, redirect_pc, e.rpc, "redirect_pc");
            end
        end
    end

    initial begin
        #(10 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_val[i] = 1'b0; m_tkn[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
        end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset state, nothing hits.
        fetch_only(32'h100, "R1");
        fetch_only(32'h248, "R1");
        // R10: insert and lookup of same index together; R8 flush follows.
        step(32'h100, 1'b1, 32'h100, 1'b1, 32'h0F0, 32'h104, "R10", "R8");
        // R3/R5: entry now hits with target.
        fetch_only(32'h100, "R5");
        // R9: correct taken prediction; R2: alias tag 5 at index 0 misses.
        step(32'h140, 1'b1, 32'h100, 1'b1, 32'h0F0, 32'h0F0, "R2", "R9");
        fetch_only(32'h100, "R3");
        // R6: not taken with entry clears taken bit; same-cycle lookup sees old (R10).
        step(32'h100, 1'b1, 32'h100, 1'b0, 32'h0F0, 32'h0F0, "R10", "R8");
        fetch_only(32'h100, "R6");
        // Loop: several iterations then exit, fetch using model predictions.
        for (int k = 0; k < 6; k++) begin
            logic t;
            t = (k < 5);
            step(32'h100, 1'b1, 32'h100, t, 32'h0F0, m_next(32'h100), "R4", "R8");
        end
        fetch_only(32'h100, "R6");
        // R7: entry with other tag at index 2 survives a not-taken miss.
        step(32'h248, 1'b1, 32'h248, 1'b1, 32'h400, 32'h24C, "R4", "R8");
        step(32'h208, 1'b1, 32'h208, 1'b0, 32'h0, 32'h20C, "R7", "R9");
        fetch_only(32'h248, "R7");
        fetch_only(32'h208, "R7");
        // R11: taken branch with alias tag replaces index 0 entry.
        step(32'h0F0, 1'b1, 32'h140, 1'b1, 32'h300, 32'h144, "R4", "R8");
        fetch_only(32'h100, "R11");
        fetch_only(32'h140, "R11");
        // R4: wrap of sequential address.
        fetch_only(32'hFFFF_FFFC, "R4");
        fetch_only(32'h0, "R4");
        repeat (3) @(posedge clk);
        check("R8", PC_W'(n_flush_seen), PC_W'(n_flush_exp), "flush count");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule